// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns one host request into the ordered series of bus cycles that a small-page NAND flash device expects. A request carries an opcode byte, an optional column, an optional page number, a flag for a 16-bit device bus and a flag for a large-density device. The sequencer then drives CLE, ALE, an active-low write strobe and an 8-bit data bus. Each bus cycle has three phases: setup, strobe and hold. The width of each phase is set in clock ticks through a small configuration word.

Before a serial-input opcode, the block first issues a read-pointer opcode. It picks that opcode from where the column falls in the page, and it rebases the column to match. Some opcodes finish as soon as their cycles are out. Other read-type opcodes wait a fixed number of ticks when no ready/busy line is in use. A reset opcode without a ready/busy line waits, then issues a status opcode and reads status bytes until the ready bit comes back set. While a request is in flight the block is busy and drops further requests. Completion is a one-clock done pulse.

Top module: `nand_cmd_seq`

## Requirements
- R1: Out of reset and whenever idle, busy and done are 0, CLE and ALE are 0, the write and read strobes are 1 and the bus is not driven.
- R2: Each bus cycle raises CLE for an opcode or ALE for an address byte and places the byte on the bus. It holds them for the setup phase, pulls the write strobe low for the strobe phase, then keeps the byte for the hold phase. Each phase lasts its configuration field plus one ticks. The fields are setup in bits [2:0], strobe in bits [5:3] and hold in bits [8:6], and all three fields reset to 7, giving 8 ticks.
- R3: A request with neither column nor page produces a single CLE cycle carrying the opcode.
- R4: A supplied column produces exactly one ALE cycle after the opcode. In 16-bit mode that byte is the column shifted right by one.
- R5: A supplied page produces ALE cycles carrying page bits [7:0] and then bits [15:8]. When the large flag is set, a third cycle follows carrying bits [19:16] with its upper nibble zero.
- R6: For opcode 0x80, a pointer opcode is issued first. A column of 512 or more gives 0x50 and the column minus 512. A column below 256 gives 0x00 and the column unchanged. Any other column gives 0x01 and the column minus 256.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 pulse done in the tick right after the last hold tick.
- R8: Any other opcode except 0xFF waits WAIT_TICKS ticks after the last hold tick before done when rb_present is 0. When rb_present is 1 it finishes like R7.
- R9: Opcode 0xFF with rb_present 0 waits WAIT_TICKS ticks, issues a 0x70 CLE cycle, then repeats read cycles until bit 6 of the sampled byte is 1, and then pulses done. Each read cycle has the read strobe low for the strobe phase, and the byte is sampled at the end of that phase. With rb_present 1, opcode 0xFF finishes like R7.
- R10: busy rises on acceptance and stays high through the done pulse. done lasts one tick. Requests arriving while busy are dropped.
- R11: Configuration writes are taken only while idle; writes while busy have no effect.
- R12: The chip-enable output is the inverse of the chip-select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Phase widths minus one: hold, strobe, setup |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_cmd | input | 8 | Opcode byte |
| req_has_col | input | 1 | Column is supplied |
| req_col | input | COL_W | Column byte offset in the page |
| req_has_page | input | 1 | Page is supplied |
| req_page | input | PAGE_W | Page number |
| req_wide | input | 1 | Device has a 16-bit bus |
| req_large | input | 1 | Device needs a third page byte |
| rb_present | input | 1 | A ready/busy line is watched elsewhere |
| ce_sel | input | 1 | Chip select request |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-tick completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven by the block |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus byte from the device |

## Verification
A wrong slot mask or slot index shows on the bus within one cycle frame: as a missing, extra or reordered byte, or as CLE where ALE belongs, and it appears at the next write-strobe rise. A wrong phase counter changes the number of ticks the write strobe stays low, or the gap between the last strobe rise and done. Both are measured tick by tick. A broken wait counter or poll flag moves done by a whole delay window, or changes how many read strobes appear before done.

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq #(
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20,
  parameter int PAGE_BYTES = 512,
  parameter int HALF_BYTES = 256,
  parameter int WAIT_TICKS = 20,
  parameter int RDY_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [8:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [7:0]        req_cmd,
  input  logic              req_has_col,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_has_page,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_wide,
  input  logic              req_large,
  input  logic              rb_present,
  input  logic              ce_sel,
  output logic              busy,
  output logic              done,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in
);
  localparam int NSLOT = 6;
  localparam int WT_W = $clog2(WAIT_TICKS + 1);
  localparam logic [7:0] RDY_MASK = 8'(1 << RDY_BIT);
  localparam logic [7:0] OP_SEQIN = 8'h80, OP_PROG = 8'h10, OP_ESET = 8'h60,
                         OP_ECONF = 8'hD0, OP_STAT = 8'h70, OP_RST = 8'hFF,
                         OP_PTRA = 8'h00, OP_PTRB = 8'h01, OP_PTRS = 8'h50;

  typedef enum logic [2:0] {ST_IDLE, ST_SEQ, ST_WAIT, ST_SCMD, ST_SRD, ST_FIN} st_t;
  typedef enum logic [1:0] {PH_SET, PH_STB, PH_HLD} ph_t;
  typedef enum logic [1:0] {TL_NONE, TL_WAIT, TL_POLL} tail_t;

  st_t              st;
  ph_t              ph;
  tail_t            tail, new_tail;
  logic [2:0]       cnt, lim, cur;
  logic [8:0]       cfg;
  logic [NSLOT-1:0] slot_mask, new_mask, rest_mask;
  logic [7:0]       slot_byte [NSLOT];
  logic [7:0]       new_byte  [NSLOT];
  logic [WT_W-1:0]  wcnt;
  logic             stat_ok, ph_end, is_seqin, drive;
  logic [COL_W-1:0] col_adj;
  logic [7:0]       ptr_op;

  assign is_seqin = (req_cmd == OP_SEQIN);

  always_comb begin
    col_adj = req_col;
    ptr_op  = OP_PTRA;
    if (is_seqin) begin
      if (req_col >= COL_W'(PAGE_BYTES)) begin
        ptr_op  = OP_PTRS;
        col_adj = req_col - COL_W'(PAGE_BYTES);
      end else if (req_col >= COL_W'(HALF_BYTES)) begin
        ptr_op  = OP_PTRB;
        col_adj = req_col - COL_W'(HALF_BYTES);
      end
    end
    if (req_wide) col_adj = col_adj >> 1;
  end

  assign new_byte[0] = ptr_op;
  assign new_byte[1] = req_cmd;
  assign new_byte[2] = 8'(col_adj);
  assign new_byte[3] = 8'(req_page);
  assign new_byte[4] = 8'(req_page >> 8);
  assign new_byte[5] = {4'b0000, 4'(req_page >> 16)};
  assign new_mask = {req_large & req_has_page, req_has_page, req_has_page,
                     req_has_col, 1'b1, is_seqin};

  always_comb begin
    case (req_cmd)
      OP_PROG, OP_ESET, OP_ECONF, OP_SEQIN, OP_STAT: new_tail = TL_NONE;
      OP_RST:  new_tail = rb_present ? TL_NONE : TL_POLL;
      default: new_tail = rb_present ? TL_NONE : TL_WAIT;
    endcase
  end

  always_comb begin
    cur = 3'd0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot_mask[i]) cur = 3'(i);
  end
  assign rest_mask = slot_mask & ~(NSLOT'(1) << cur);

  always_comb begin
    case (ph)
      PH_SET:  lim = cfg[2:0];
      PH_STB:  lim = cfg[5:3];
      default: lim = cfg[8:6];
    endcase
  end
  assign ph_end = (cnt == lim);

  assign drive       = (st == ST_SEQ) || (st == ST_SCMD);
  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_FIN);
  assign nand_ce_n   = ~ce_sel;
  assign nand_cle    = ((st == ST_SEQ) && (cur < 3'd2)) || (st == ST_SCMD);
  assign nand_ale    = (st == ST_SEQ) && (cur >= 3'd2);
  assign nand_we_n   = !(drive && (ph == PH_STB));
  assign nand_re_n   = !((st == ST_SRD) && (ph == PH_STB));
  assign nand_dq_oe  = drive;
  assign nand_dq_out = (st == ST_SCMD) ? OP_STAT : (st == ST_SEQ) ? slot_byte[cur] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_SET;
      tail      <= TL_NONE;
      cnt       <= '0;
      cfg       <= 9'h1FF;
      slot_mask <= '0;
      wcnt      <= '0;
      stat_ok   <= 1'b0;
      for (int i = 0; i < NSLOT; i++) slot_byte[i] <= 8'h00;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cfg_we) cfg <= cfg_wdata;
          if (req_valid) begin
            st        <= ST_SEQ;
            ph        <= PH_SET;
            cnt       <= '0;
            slot_mask <= new_mask;
            tail      <= new_tail;
            for (int i = 0; i < NSLOT; i++) slot_byte[i] <= new_byte[i];
          end
        end
        ST_WAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WT_W'(WAIT_TICKS - 1)) begin
            wcnt <= '0;
            if (tail == TL_POLL) begin
              st  <= ST_SCMD;
              ph  <= PH_SET;
              cnt <= '0;
            end else begin
              st <= ST_FIN;
            end
          end
        end
        ST_FIN: st <= ST_IDLE;
        default: begin
          if (ph_end) begin
            cnt <= '0;
            case (ph)
              PH_SET:  ph <= PH_STB;
              PH_STB:  ph <= PH_HLD;
              default: ph <= PH_SET;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
          if ((st == ST_SRD) && (ph == PH_STB) && ph_end)
            stat_ok <= |(nand_dq_in & RDY_MASK);
          if ((ph == PH_HLD) && ph_end) begin
            if (st == ST_SEQ) begin
              slot_mask <= rest_mask;
              if (rest_mask == '0) st <= (tail == TL_NONE) ? ST_FIN : ST_WAIT;
            end else if (st == ST_SCMD) begin
              st <= ST_SRD;
            end else if (stat_ok) begin
              st <= ST_FIN;
            end
          end
        end
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !done));
  // R2
  strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_cle != nand_ale) && nand_dq_oe);
  // R2
  byte_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> $stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale));
  // R2
  byte_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> $stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale));
  // R9
  read_strobe_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R10
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/nand_cmd_seq_tb.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_has_col = 1'b0, req_has_page = 1'b0;
  logic req_wide = 1'b0, req_large = 1'b0, rb_present = 1'b0, ce_sel = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [9:0] req_col = '0;
  logic [19:0] req_page = '0;
  logic busy, done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out, nand_dq_in;

  always #5 clk = ~clk;

  nand_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_has_col(req_has_col),
    .req_col(req_col), .req_has_page(req_has_page), .req_page(req_page),
    .req_wide(req_wide), .req_large(req_large), .rb_present(rb_present),
    .ce_sel(ce_sel), .busy(busy), .done(done), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in));

  int nchk = 0, nerr = 0;
  int nlog = 0, lowcnt = 0, gap = 0, setupcnt = 0, re_count = 0;
  int done_cnt = 0, done_gap = 0, nbusy_reads = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [9:0] log_ent [16];
  int log_low [16];

  assign nand_dq_in = (re_count > nbusy_reads) ? 8'h40 : 8'hBF;

  always @(negedge clk) begin
    if (!nand_we_n) lowcnt++;
    if (nand_we_n && !prev_we) begin
      if (nlog < 16) begin
        log_ent[nlog] = {nand_cle, nand_ale, nand_dq_out};
        log_low[nlog] = lowcnt;
      end
      nlog++;
      lowcnt = 0;
      gap = 1;
    end else gap++;
    if (nand_we_n && (nand_cle || nand_ale) && nlog == 0) setupcnt++;
    if (!nand_re_n && prev_re) re_count++;
    if (done) begin done_cnt++; done_gap = gap; end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cyc(string tag, int i, bit is_cmd, logic [7:0] b);
    chk(tag, (i < 16) ? int'(log_ent[i]) : -1, int'({is_cmd, !is_cmd, b}));
  endtask

  task automatic clear_mon();
    @(posedge clk);
    nlog = 0; lowcnt = 0; setupcnt = 0; re_count = 0; done_cnt = 0; done_gap = 0;
  endtask

  task automatic issue(logic [7:0] c, bit hc, logic [9:0] col, bit hp, logic [19:0] pg,
                       bit w, bit lg, bit rb);
    clear_mon();
    @(negedge clk);
    req_cmd = c; req_has_col = hc; req_col = col; req_has_page = hp; req_page = pg;
    req_wide = w; req_large = lg; rb_present = rb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    if (done_cnt == 0) begin
      nerr++; nchk++;
      $display("FAIL %s: actual=no done expected=done", tag);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(logic [8:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 strobes/latches", int'({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}), 'b11000);
  endtask

  task automatic t_default_status();
    issue(8'h70, 0, 0, 0, 0, 0, 0, 0);
    wait_done("R3 status");
    chk("R3 count", nlog, 1);
    chk_cyc("R3 byte", 0, 1, 8'h70);
    chk("R2 default setup", setupcnt, 8);
    chk("R2 default strobe", log_low[0], 8);
    chk("R7 gap default", done_gap, 9);
    chk("R10 one done", done_cnt, 1);
  endtask

  task automatic t_erase_page();
    write_cfg({3'd2, 3'd1, 3'd0});
    issue(8'h60, 0, 0, 1, 20'h12345, 0, 0, 0);
    wait_done("R5 erase");
    chk("R5 count", nlog, 3);
    chk_cyc("R5 cmd", 0, 1, 8'h60);
    chk_cyc("R5 lo", 1, 0, 8'h45);
    chk_cyc("R5 hi", 2, 0, 8'h23);
    chk("R2 setup", setupcnt, 1);
    chk("R2 strobe", log_low[1], 2);
    chk("R7 gap", done_gap, 4);
  endtask

  task automatic t_large_page();
    issue(8'h60, 0, 0, 1, 20'hABCDE, 0, 1, 0);
    wait_done("R5 large");
    chk("R5 large count", nlog, 4);
    chk_cyc("R5 large b1", 1, 0, 8'hDE);
    chk_cyc("R5 large b2", 2, 0, 8'hBC);
    chk_cyc("R5 large b3", 3, 0, 8'h0A);
  endtask

  task automatic t_seqin();
    issue(8'h80, 1, 10'd100, 1, 20'h00203, 0, 0, 0);
    wait_done("R6 low");
    chk("R6 low count", nlog, 5);
    chk_cyc("R6 ptr a", 0, 1, 8'h00);
    chk_cyc("R6 op", 1, 1, 8'h80);
    chk_cyc("R4 col", 2, 0, 8'h64);
    chk_cyc("R5 p0", 3, 0, 8'h03);
    chk_cyc("R5 p1", 4, 0, 8'h02);
    chk("R7 seqin gap", done_gap, 4);
    issue(8'h80, 1, 10'd300, 0, 0, 0, 0, 0);
    wait_done("R6 mid");
    chk("R6 mid count", nlog, 3);
    chk_cyc("R6 ptr b", 0, 1, 8'h01);
    chk_cyc("R6 mid col", 2, 0, 8'h2C);
    issue(8'h80, 1, 10'd520, 0, 0, 0, 0, 0);
    wait_done("R6 spare");
    chk_cyc("R6 ptr spare", 0, 1, 8'h50);
    chk_cyc("R6 spare col", 2, 0, 8'h08);
    issue(8'h80, 1, 10'd300, 0, 0, 1, 0, 0);
    wait_done("R4 wide");
    chk_cyc("R4 wide ptr", 0, 1, 8'h01);
    chk_cyc("R4 wide col", 2, 0, 8'h16);
  endtask

  task automatic t_read_wait();
    issue(8'h00, 1, 10'd5, 0, 0, 0, 0, 0);
    wait_done("R8 wait");
    chk("R8 count", nlog, 2);
    chk_cyc("R4 read col", 1, 0, 8'h05);
    chk("R8 delayed gap", done_gap, 24);
    issue(8'h00, 1, 10'd5, 0, 0, 0, 0, 1);
    wait_done("R8 rb");
    chk("R8 rb gap", done_gap, 4);
  endtask

  task automatic t_reset_poll();
    nbusy_reads = 3;
    issue(8'hFF, 0, 0, 0, 0, 0, 0, 0);
    wait_done("R9 poll");
    chk("R9 count", nlog, 2);
    chk_cyc("R9 reset op", 0, 1, 8'hFF);
    chk_cyc("R9 status op", 1, 1, 8'h70);
    chk("R9 reads", re_count, 4);
    chk("R9 one done", done_cnt, 1);
    issue(8'hFF, 0, 0, 0, 0, 0, 0, 1);
    wait_done("R9 rb");
    chk("R9 rb reads", re_count, 0);
    chk("R9 rb gap", done_gap, 4);
  endtask

  task automatic t_busy_ignore();
    issue(8'h10, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 busy after accept", int'(busy), 1);
    @(negedge clk); req_cmd = 8'h60; req_valid = 1'b1; cfg_we = 1'b1; cfg_wdata = 9'h000;
    @(negedge clk); req_valid = 1'b0; cfg_we = 1'b0;
    wait_done("R10 ignore");
    repeat (40) @(negedge clk);
    chk("R10 count", nlog, 1);
    chk_cyc("R10 byte", 0, 1, 8'h10);
    chk("R10 dones", done_cnt, 1);
    chk("R10 idle", int'(busy), 0);
    issue(8'h70, 0, 0, 0, 0, 0, 0, 0);
    wait_done("R11 check");
    chk("R11 strobe kept", log_low[0], 2);
  endtask

  task automatic t_chip_enable();
    @(negedge clk); ce_sel = 1'b1;
    @(negedge clk); chk("R12 selected", int'(nand_ce_n), 0);
    ce_sel = 1'b0;
    @(negedge clk); chk("R12 deselected", int'(nand_ce_n), 1);
  endtask

  initial begin
    #1_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_default_status();
    t_erase_page();
    t_large_page();
    t_seqin();
    t_read_wait();
    t_reset_poll();
    t_busy_ignore();
    t_chip_enable();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule